// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Data Cache

This block is a small fully associative store that sits beside a direct-mapped data cache and keeps blocks that the cache has recently thrown out. When the cache misses, it presents the missing address on the lookup port. In the same cycle it also presents the block it is about to displace from that cache line, if there is one, on the evict port. All stored tags are compared in parallel against the missing block address. On a match, the stored block is returned to the cache one cycle later and the displaced block takes its slot. The two blocks are swapped, and no memory access is needed. On no match, the displaced block is placed into the buffer and the cache goes on to memory.

Entries are chosen for replacement by least-recent use, and a free slot is always taken first. Each entry remembers whether its block was modified. A modified block that is pushed out of the buffer is presented on a writeback output so that it can be sent to memory. The tag is the whole block address, meaning the byte address with the in-block offset removed.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is invalid: rsp_valid and wb_valid are 0, and the first lookup misses.
- R2: A lookup whose block address (address bits above the log2(BLOCK_BYTES) offset bits; the offset bits are ignored) equals a valid entry's tag gives, one cycle later, rsp_valid=1, rsp_hit=1, rsp_data equal to that entry's block and rsp_dirty equal to its dirty flag.
- R3: Every lookup gets exactly one response one cycle later. A lookup that matches no valid entry gives rsp_valid=1 and rsp_hit=0.
- R4: A lookup hit accompanied by an evict (swap) stores the evicted block, its address and its dirty flag in the hit entry. The previously stored block then no longer hits.
- R5: A lookup hit with no evict invalidates the hit entry, so a repeated lookup of the same block misses.
- R6: An evict that does not swap fills an invalid entry whenever one exists. This displaces nothing: wb_valid stays 0 and every stored block still hits.
- R7: When all entries are valid, an evict that does not swap replaces the entry least recently filled or swapped into.
- R8: A displaced entry that is valid and dirty appears one cycle later as wb_valid=1, with wb_addr equal to its block address (offset bits zero) and wb_data equal to its block. A clean displaced entry gives wb_valid=0.
- R9: An evict with no lookup is inserted as on a miss and produces no response (rsp_valid=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Main cache missed; search the buffer |
| lookup_addr | input | ADDR_W | Byte address of the missing block |
| evict_valid | input | 1 | A block is being displaced from the main cache |
| evict_addr | input | ADDR_W | Address of the displaced block |
| evict_data | input | 8*BLOCK_BYTES | Contents of the displaced block |
| evict_dirty | input | 1 | Displaced block is modified |
| rsp_valid | output | 1 | Response to the lookup of the previous cycle |
| rsp_hit | output | 1 | Lookup found its block |
| rsp_dirty | output | 1 | Returned block is modified |
| rsp_data | output | 8*BLOCK_BYTES | Returned block, meaningful when rsp_hit is 1 |
| wb_valid | output | 1 | A dirty entry was pushed out |
| wb_addr | output | ADDR_W | Block address of the pushed-out entry |
| wb_data | output | 8*BLOCK_BYTES | Contents of the pushed-out entry |

## Verification
The bench builds the block with its defaults: four entries, 32-bit addresses and 32-byte blocks. Random traffic draws from a pool of twelve block addresses. This is three times the capacity, so lookups both hit and miss, the buffer runs full again and again, and least-recent-use displacement and dirty writebacks happen often. Lookups carry random offsets, which exercises the rule that the offset is ignored. Directed steps cover filling from empty, a swap, a hit that empties its slot, and an evict with no lookup.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // What one request does to the buffer
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,  // nothing stored or removed
    ACT_SWAP = 2'd1,  // hit, evicted block takes the hit slot
    ACT_TAKE = 2'd2,  // hit, no block offered: slot emptied
    ACT_FILL = 2'd3   // evicted block inserted at the replacement slot
  } vc_action_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 27,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0]              slot_valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0]   slot_tag,
  input  logic [TAG_W-1:0]                probe_tag,
  output logic                            found,
  output logic [IDX_W-1:0]                found_idx
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = slot_valid[g] && (slot_tag[g] == probe_tag);
  end

  always_comb begin
    found_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) found_idx = IDX_W'(i);
    end
  end

  assign found = |match_vec;

  // R2: a block lives in at most one slot
  p_single_match_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic [IDX_W-1:0]   victim_idx
);

  // Age 0 = most recent, ENTRIES-1 = oldest; the ages stay a permutation
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;
  logic                          have_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)
          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx])
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    have_free  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!have_free && !slot_valid[i]) begin
        victim_idx = IDX_W'(i);
        have_free  = 1'b1;
      end
    end
    if (!have_free) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
      end
    end
  end

  // R7: a touched slot becomes the most recent one
  p_touch_mru_r7: assert property (@(posedge clk) disable iff (rst)
    touch |=> age_q[$past(touch_idx)] == '0);

endmodule

// File: rtl/vc_data_store.sv
module vc_data_store #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 256,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [ENTRIES];

  // Registered reads return the contents before this cycle's write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vc_pkg::*;
#(
  parameter int ENTRIES     = 4,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lookup_valid,
  input  logic [ADDR_W-1:0]        lookup_addr,
  input  logic                     evict_valid,
  input  logic [ADDR_W-1:0]        evict_addr,
  input  logic [8*BLOCK_BYTES-1:0] evict_data,
  input  logic                     evict_dirty,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_dirty,
  output logic [8*BLOCK_BYTES-1:0] rsp_data,
  output logic                     wb_valid,
  output logic [ADDR_W-1:0]        wb_addr,
  output logic [8*BLOCK_BYTES-1:0] wb_data
);

  localparam int OFS_W  = $clog2(BLOCK_BYTES);
  localparam int TAG_W  = ADDR_W - OFS_W;
  localparam int DATA_W = 8 * BLOCK_BYTES;
  localparam int IDX_W  = idx_width(ENTRIES);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            dirty_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;

  logic [TAG_W-1:0] probe_tag, in_tag;
  logic             found;
  logic [IDX_W-1:0] found_idx, victim_idx, wr_idx;
  logic             store_we, push_out;
  vc_action_e       action;

  assign probe_tag = lookup_addr[ADDR_W-1:OFS_W];
  assign in_tag    = evict_addr[ADDR_W-1:OFS_W];

  vc_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .slot_valid (valid_q),
    .slot_tag   (tag_q),
    .probe_tag  (probe_tag),
    .found      (found),
    .found_idx  (found_idx)
  );

  always_comb begin
    if (lookup_valid && found)
      action = evict_valid ? ACT_SWAP : ACT_TAKE;
    else if (evict_valid)
      action = ACT_FILL;
    else
      action = ACT_IDLE;
  end

  assign store_we = (action == ACT_SWAP) || (action == ACT_FILL);
  assign wr_idx   = (action == ACT_SWAP) ? found_idx : victim_idx;
  assign push_out = (action == ACT_FILL) && valid_q[victim_idx] && dirty_q[victim_idx];

  vc_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .slot_valid (valid_q),
    .touch      (store_we),
    .touch_idx  (wr_idx),
    .victim_idx (victim_idx)
  );

  vc_data_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .we      (store_we),
    .waddr   (wr_idx),
    .wdata   (evict_data),
    .raddr_a (found_idx),
    .rdata_a (rsp_data),
    .raddr_b (victim_idx),
    .rdata_b (wb_data)
  );

  // Slot bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
    end else begin
      unique case (action)
        ACT_SWAP, ACT_FILL: begin
          valid_q[wr_idx] <= 1'b1;
          dirty_q[wr_idx] <= evict_dirty;
          tag_q[wr_idx]   <= in_tag;
        end
        ACT_TAKE: valid_q[found_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  // Registered response and writeback control
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dirty <= 1'b0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
    end else begin
      rsp_valid <= lookup_valid;
      rsp_hit   <= lookup_valid && found;
      rsp_dirty <= lookup_valid && found && dirty_q[found_idx];
      wb_valid  <= push_out;
      wb_addr   <= {tag_q[victim_idx], {OFS_W{1'b0}}};
    end
  end

  // R1: outputs quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !wb_valid));

  // R3: every lookup is answered in the next cycle
  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> rsp_valid);

  // R2: a hit is only reported as part of a response
  p_hit_in_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  // R8: writeback only follows an insertion that was not a swap
  p_wb_from_fill_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ($past(evict_valid) && !rsp_hit));

endmodule

// File: tb/tb_victim_buffer.sv
module tb_victim_buffer;

  localparam int ENTRIES     = 4;
  localparam int ADDR_W      = 32;
  localparam int BLOCK_BYTES = 32;
  localparam int OFS_W       = 5;
  localparam int TAG_W       = ADDR_W - OFS_W;
  localparam int DATA_W      = 8 * BLOCK_BYTES;
  localparam int POOL        = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              lookup_valid, evict_valid, evict_dirty;
  logic [ADDR_W-1:0] lookup_addr, evict_addr;
  logic [DATA_W-1:0] evict_data;
  logic              rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [DATA_W-1:0] rsp_data, wb_data;
  logic [ADDR_W-1:0] wb_addr;

  always #4 clk = ~clk;

  victim_buffer #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) dut (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .evict_data(evict_data), .evict_dirty(evict_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Reference model
  bit              m_valid [ENTRIES];
  bit              m_dirty [ENTRIES];
  logic [TAG_W-1:0] m_tag  [ENTRIES];
  logic [DATA_W-1:0] m_data [ENTRIES];
  int              m_stamp [ENTRIES];
  int              now_stamp = 0;
  logic [TAG_W-1:0] pool [POOL];

  task automatic chk(string what, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rand_block();
    logic [DATA_W-1:0] v;
    for (int k = 0; k < DATA_W / 32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic int model_find(logic [TAG_W-1:0] t);
    for (int i = 0; i < ENTRIES; i++) if (m_valid[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int model_victim();
    int v = 0;
    for (int i = 0; i < ENTRIES; i++) if (!m_valid[i]) return i;
    for (int i = 1; i < ENTRIES; i++) if (m_stamp[i] < m_stamp[v]) v = i;
    return v;
  endfunction

  // One request; outputs checked in the cycle after the capturing edge
  task automatic do_op(bit lv, logic [ADDR_W-1:0] la, bit ev, logic [ADDR_W-1:0] ea,
                       logic [DATA_W-1:0] ed, bit edt, string tag);
    int h, v, w;
    bit e_hit, e_dirty, e_wb;
    logic [DATA_W-1:0] e_data, e_wbd;
    logic [ADDR_W-1:0] e_wba;
    h = lv ? model_find(la[ADDR_W-1:OFS_W]) : -1;
    e_hit = (h >= 0);
    e_dirty = e_hit ? m_dirty[h] : 1'b0;
    e_data = e_hit ? m_data[h] : '0;
    e_wb = 1'b0; e_wba = '0; e_wbd = '0;
    w = -1;
    if (e_hit && ev) w = h;
    else if (e_hit) m_valid[h] = 1'b0;
    else if (ev) begin
      v = model_victim();
      if (m_valid[v] && m_dirty[v]) begin
        e_wb = 1'b1; e_wba = {m_tag[v], {OFS_W{1'b0}}}; e_wbd = m_data[v];
      end
      w = v;
    end
    if (w >= 0) begin
      m_valid[w] = 1'b1; m_dirty[w] = edt; m_tag[w] = ea[ADDR_W-1:OFS_W];
      m_data[w] = ed; now_stamp++; m_stamp[w] = now_stamp;
    end
    lookup_valid = lv; lookup_addr = la;
    evict_valid = ev; evict_addr = ea; evict_data = ed; evict_dirty = edt;
    @(posedge clk);
    @(negedge clk);
    lookup_valid = 1'b0; evict_valid = 1'b0;
    chk("rsp_valid", {tag, " R3"}, DATA_W'(rsp_valid), DATA_W'(lv));
    if (lv) begin
      chk("rsp_hit", {tag, " R2"}, DATA_W'(rsp_hit), DATA_W'(e_hit));
      if (e_hit) begin
        chk("rsp_data", {tag, " R2"}, rsp_data, e_data);
        chk("rsp_dirty", {tag, " R2"}, DATA_W'(rsp_dirty), DATA_W'(e_dirty));
      end
    end
    chk("wb_valid", {tag, " R8"}, DATA_W'(wb_valid), DATA_W'(e_wb));
    if (e_wb) begin
      chk("wb_addr", {tag, " R8"}, DATA_W'(wb_addr), DATA_W'(e_wba));
      chk("wb_data", {tag, " R8"}, wb_data, e_wbd);
    end
  endtask

  function automatic logic [ADDR_W-1:0] baddr(int p, logic [OFS_W-1:0] ofs);
    return {pool[p], ofs};
  endfunction

  initial begin
    process::self().srandom(32'd20240611);
    for (int i = 0; i < POOL; i++) pool[i] = TAG_W'(32'h0A_0000 + i * 37);
    for (int i = 0; i < ENTRIES; i++) begin
      m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; m_stamp[i] = 0;
    end
    rst = 1'b1; lookup_valid = 1'b0; evict_valid = 1'b0; evict_dirty = 1'b0;
    lookup_addr = '0; evict_addr = '0; evict_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("rsp_valid after reset", "R1", DATA_W'(rsp_valid), '0);
    chk("wb_valid after reset", "R1", DATA_W'(wb_valid), '0);

    // R1: first lookup misses; R6: fill four slots from empty, no writeback
    do_op(1, baddr(11, 5'd0), 0, '0, '0, 0, "R1");
    do_op(1, baddr(10, 5'd3), 1, baddr(0, 0), rand_block(), 1, "R6");
    do_op(1, baddr(10, 5'd3), 1, baddr(1, 0), rand_block(), 0, "R6");
    do_op(0, '0,               1, baddr(2, 0), rand_block(), 1, "R6");
    do_op(1, baddr(9, 5'd7),  1, baddr(3, 0), rand_block(), 0, "R6");
    // R4: hit on block 2 with odd offset, swapped for block 4
    do_op(1, baddr(2, 5'd29), 1, baddr(4, 0), rand_block(), 1, "R4");
    // R4: block 2 gone; R7: block 0 is oldest, dirty -> written back
    do_op(1, baddr(2, 5'd1),  1, baddr(5, 0), rand_block(), 0, "R4 R7");
    // R7: next oldest is block 1 (clean)
    do_op(1, baddr(8, 5'd1),  1, baddr(6, 0), rand_block(), 1, "R7");
    // R5: hit without evict empties the slot, second lookup misses
    do_op(1, baddr(4, 5'd2),  0, '0, '0, 0, "R5");
    do_op(1, baddr(4, 5'd2),  0, '0, '0, 0, "R5");
    // R9: evict only, fills the freed slot, no response
    do_op(0, '0,               1, baddr(7, 0), rand_block(), 1, "R9 R6");
    do_op(1, baddr(7, 5'd31), 0, '0, '0, 0, "R9");

    // Random traffic over a pool larger than the buffer
    for (int n = 0; n < 3000; n++) begin
      int lp, ep, tries;
      bit lv, ev;
      lv = ($urandom_range(0, 9) != 0);
      lp = $urandom_range(0, POOL - 1);
      ev = ($urandom_range(0, 4) != 0);
      ep = -1;
      if (ev) begin
        tries = 0;
        while (tries < 20) begin
          int c = $urandom_range(0, POOL - 1);
          if (model_find(pool[c]) < 0 && !(lv && c == lp)) begin ep = c; break; end
          tries++;
        end
      end
      if (ep < 0) ev = 1'b0;
      do_op(lv, baddr(lp, OFS_W'($urandom())), ev, ev ? baddr(ep, 0) : '0,
            ev ? rand_block() : '0, ev ? 1'($urandom()) : 1'b0, "rand R7");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule